// File: doc/BRIEF.md
# I2C Target Register Bank with Byte FIFOs

This block is the software-facing front end of an I2C-compatible target controller. A simple request/acknowledge register port reaches two 32-bit words: a control/status word and a data word. Writes to the data word queue bytes in a transmit FIFO, which the serial protocol engine drains. Bytes that the engine receives land in a receive FIFO, and reads of the data word pop them. Both FIFOs have the same power-of-two depth, which is set by a parameter.

The control word drives the engine's enable, its sample-rate select and its 7-bit own address. The engine sends back a busy flag and the sensed levels of the clock and data lines, and these appear in the status bits of the same word. A single level interrupt reports an OR of three FIFO conditions. Each condition has its own mask bit, and the whole interrupt is gated by the enable. Clearing the enable bit flushes both FIFOs and keeps them empty until the block is enabled again.

Top module: `tgt_regbank`

## Requirements
- R1: After reset the engine enable, sample-rate select, own address and interrupt are all zero, and both FIFOs are empty.
- R2: Control word fields: bit 0 enable, bit 3 sample-rate select, bits 10:4 own address, bit 11 mask for receive-available, bit 12 mask for receive-full, bit 13 mask for transmit-empty. Each field drives its engine output and reads back at its position.
- R3: Bits 18:15 of the control word read log2 of the FIFO depth. Bits 1, 2, 14 and 24:19 read as zero.
- R4: Status bits of the control word are read-only: 25 receive data available, 26 receive full, 27 transmit empty, 28 transmit full, 29 clock-line sense, 30 data-line sense, 31 engine busy.
- R5: While the block is enabled, a full-word write to the data word pushes bits 7:0 into the transmit FIFO. The engine sees the oldest byte on tx_rd_data with tx_rd_avail high, and tx_rd removes it. With the FIFO empty, tx_rd_data shows 0xFF.
- R6: While the block is enabled, rx_wr_valid pushes rx_wr_data into the receive FIFO. A read of the data word returns and removes the oldest byte in bits 7:0, with bits 31:8 zero. A read of an empty receive FIFO returns zero.
- R7: A push into a full FIFO is dropped and the stored bytes are left unchanged.
- R8: A control write with bit 1 set flushes the receive FIFO, and one with bit 2 set flushes the transmit FIFO. Both bits read back as zero.
- R9: While the enable is zero, both FIFOs are empty, pushes from either side are dropped and the interrupt is low.
- R10: irq = enable AND ((bit11 AND receive not empty) OR (bit12 AND receive full) OR (bit13 AND transmit empty)).
- R11: A write with any byte enable low has no effect on either word.
- R12: Every request is acknowledged exactly one cycle later, with the read data valid in that cycle. Word offsets other than 0x0 (control) and 0x4 (data) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; 0x0 control, 0x4 data |
| req_be | input | 4 | Byte enables; writes need all four |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with rsp_ack |
| eng_enable | output | 1 | Engine enable |
| eng_slow_sample | output | 1 | Selects the slower line sample rate |
| eng_own_addr | output | 7 | Own target address |
| eng_busy | input | 1 | Engine transaction in progress |
| eng_scl_sense | input | 1 | Sensed clock-line level |
| eng_sda_sense | input | 1 | Sensed data-line level |
| rx_wr_valid | input | 1 | Engine delivers a received byte |
| rx_wr_data | input | 8 | Received byte |
| tx_rd | input | 1 | Engine consumes the head transmit byte |
| tx_rd_data | output | 8 | Head transmit byte, 0xFF when empty |
| tx_rd_avail | output | 1 | Transmit FIFO holds a byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that requests are single-cycle pulses and that the address always has its two low bits at zero. They also assume that the engine-side strobes are held low during reset. The bench issues each request for exactly one cycle, with a gap before the next one. It changes the engine strobes and the sense inputs only on falling edges. All data-word traffic uses word-aligned offsets, and narrow writes appear only where they are the stimulus under test.

// File: rtl/tgt_regbank_pkg.sv
package tgt_regbank_pkg;

  localparam int B_EN       = 0;
  localparam int B_CLR_RX   = 1;
  localparam int B_CLR_TX   = 2;
  localparam int B_SLOW     = 3;
  localparam int B_ADDR_LO  = 4;
  localparam int B_IE_RXA   = 11;
  localparam int B_IE_RXF   = 12;
  localparam int B_IE_TXE   = 13;
  localparam int B_DEPTH_LO = 15;
  localparam int B_RX_AVAIL = 25;
  localparam int B_RX_FULL  = 26;
  localparam int B_TX_EMPTY = 27;
  localparam int B_TX_FULL  = 28;
  localparam int B_SCL      = 29;
  localparam int B_SDA      = 30;
  localparam int B_BUSY     = 31;

  typedef struct packed {
    logic       ie_txe;
    logic       ie_rxf;
    logic       ie_rxa;
    logic [6:0] own;
    logic       slow;
    logic       en;
  } cfg_t;

  typedef struct packed {
    logic busy;
    logic sda;
    logic scl;
    logic tx_full;
    logic tx_empty;
    logic rx_full;
    logic rx_avail;
  } stat_t;

  function automatic bit is_pow2(int v);
    return (v >= 1) && ((v & (v - 1)) == 0);
  endfunction

  function automatic logic [3:0] depth_code(int v);
    int k;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if ((1 << i) < v) k = i + 1;
    end
    return 4'(k);
  endfunction

  function automatic cfg_t decode_ctrl(logic [31:0] w);
    cfg_t c;
    c.en     = w[B_EN];
    c.slow   = w[B_SLOW];
    c.own    = w[B_ADDR_LO +: 7];
    c.ie_rxa = w[B_IE_RXA];
    c.ie_rxf = w[B_IE_RXF];
    c.ie_txe = w[B_IE_TXE];
    return c;
  endfunction

  function automatic logic [31:0] encode_ctrl(cfg_t c, logic [3:0] dc, stat_t s);
    logic [31:0] w;
    w = '0;
    w[B_EN]             = c.en;
    w[B_SLOW]           = c.slow;
    w[B_ADDR_LO +: 7]   = c.own;
    w[B_IE_RXA]         = c.ie_rxa;
    w[B_IE_RXF]         = c.ie_rxf;
    w[B_IE_TXE]         = c.ie_txe;
    w[B_DEPTH_LO +: 4]  = dc;
    w[B_RX_AVAIL]       = s.rx_avail;
    w[B_RX_FULL]        = s.rx_full;
    w[B_TX_EMPTY]       = s.tx_empty;
    w[B_TX_FULL]        = s.tx_full;
    w[B_SCL]            = s.scl;
    w[B_SDA]            = s.sda;
    w[B_BUSY]           = s.busy;
    return w;
  endfunction

  function automatic logic irq_term(cfg_t c, logic rx_avail, logic rx_full, logic tx_empty);
    return c.en & ((c.ie_rxa & rx_avail) | (c.ie_rxf & rx_full) | (c.ie_txe & tx_empty));
  endfunction

endpackage

// File: rtl/tgt_byte_fifo.sv
module tgt_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             push_drop,
  output logic             pop_ok
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             push_ok;

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign push_ok   = push & ~full & ~flush;
  assign push_drop = push & full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign head      = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

endmodule

// File: rtl/tgt_ctrl_reg.sv
module tgt_ctrl_reg
  import tgt_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output cfg_t        cfg,
  output logic        clr_rx,
  output logic        clr_tx,
  output logic        going_off
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '0;
    else if (wr) cfg <= decode_ctrl(wdata);
  end

  assign clr_rx    = wr & wdata[B_CLR_RX];
  assign clr_tx    = wr & wdata[B_CLR_TX];
  assign going_off = wr & ~wdata[B_EN];

endmodule

// File: rtl/tgt_irq_gen.sv
module tgt_irq_gen
  import tgt_regbank_pkg::*;
(
  input  cfg_t cfg,
  input  logic rx_avail,
  input  logic rx_full,
  input  logic tx_empty,
  output logic irq
);
  assign irq = irq_term(cfg, rx_avail, rx_full, tx_empty);
endmodule

// File: rtl/tgt_regbank.sv
module tgt_regbank
  import tgt_regbank_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ack,
  output logic [31:0]       rsp_rdata,
  output logic              eng_enable,
  output logic              eng_slow_sample,
  output logic [6:0]        eng_own_addr,
  input  logic              eng_busy,
  input  logic              eng_scl_sense,
  input  logic              eng_sda_sense,
  input  logic              rx_wr_valid,
  input  logic [7:0]        rx_wr_data,
  input  logic              tx_rd,
  output logic [7:0]        tx_rd_data,
  output logic              tx_rd_avail,
  output logic              irq
);
  localparam int          WW         = ADDR_W - 2;
  localparam logic [3:0]  DEPTH_CODE = depth_code(FIFO_DEPTH);

  if (!is_pow2(FIFO_DEPTH) || FIFO_DEPTH > 32768) begin : g_bad_depth
    $error("FIFO_DEPTH must be a power of two between 1 and 32768");
  end
  if (ADDR_W < 3) begin : g_bad_addr
    $error("ADDR_W must be at least 3");
  end

  cfg_t          cfg;
  logic [WW-1:0] word;
  logic          sel_ctrl, sel_data, full_word;
  logic          ctrl_wr, data_wr, data_rd;
  logic          clr_rx, clr_tx, going_off;
  logic          rx_flush, tx_flush;
  logic          rx_empty, rx_full, tx_empty, tx_full;
  logic [7:0]    rx_head, tx_head;
  logic          rx_push_drop, tx_push_drop, rx_pop_ok, tx_pop_ok;
  stat_t         st;
  logic [31:0]   rd_word;

  assign word      = req_addr[ADDR_W-1:2];
  assign sel_ctrl  = (word == WW'(0));
  assign sel_data  = (word == WW'(1));
  assign full_word = &req_be;
  assign ctrl_wr   = req_valid & req_write & full_word & sel_ctrl;
  assign data_wr   = req_valid & req_write & full_word & sel_data & cfg.en;
  assign data_rd   = req_valid & ~req_write & sel_data;

  tgt_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctrl_wr),
    .wdata     (req_wdata),
    .cfg       (cfg),
    .clr_rx    (clr_rx),
    .clr_tx    (clr_tx),
    .going_off (going_off)
  );

  assign rx_flush = ~cfg.en | clr_rx | going_off;
  assign tx_flush = ~cfg.en | clr_tx | going_off;

  tgt_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rx_wr_valid),
    .push_data (rx_wr_data),
    .pop       (data_rd),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full),
    .push_drop (rx_push_drop),
    .pop_ok    (rx_pop_ok)
  );

  tgt_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (data_wr),
    .push_data (req_wdata[7:0]),
    .pop       (tx_rd),
    .head      (tx_head),
    .empty     (tx_empty),
    .full      (tx_full),
    .push_drop (tx_push_drop),
    .pop_ok    (tx_pop_ok)
  );

  tgt_irq_gen u_irq (
    .cfg      (cfg),
    .rx_avail (~rx_empty),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .irq      (irq)
  );

  assign st.busy     = eng_busy;
  assign st.sda      = eng_sda_sense;
  assign st.scl      = eng_scl_sense;
  assign st.tx_full  = tx_full;
  assign st.tx_empty = tx_empty;
  assign st.rx_full  = rx_full;
  assign st.rx_avail = ~rx_empty;

  always_comb begin
    rd_word = '0;
    if (sel_ctrl)      rd_word = encode_ctrl(cfg, DEPTH_CODE, st);
    else if (sel_data) rd_word = {24'b0, rx_empty ? 8'h00 : rx_head};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack   <= req_valid;
      rsp_rdata <= (req_valid & ~req_write) ? rd_word : '0;
    end
  end

  assign eng_enable      = cfg.en;
  assign eng_slow_sample = cfg.slow;
  assign eng_own_addr    = cfg.own;
  assign tx_rd_avail     = ~tx_empty;
  assign tx_rd_data      = tx_empty ? 8'hFF : tx_head;

endmodule

// File: rtl/tgt_regbank_chk.sv
module tgt_regbank_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic              rsp_ack,
  input logic [31:0]       rsp_rdata,
  input logic              eng_enable,
  input logic [6:0]        eng_own_addr,
  input logic              tx_rd,
  input logic              tx_rd_avail,
  input logic              tx_full,
  input logic              tx_push_drop,
  input logic              irq
);
  logic ctrl_rd_q, data_rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_rd_q <= 1'b0;
      data_rd_q <= 1'b0;
    end else begin
      ctrl_rd_q <= req_valid & ~req_write & (req_addr[ADDR_W-1:2] == '0);
      data_rd_q <= req_valid & ~req_write & (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
    end
  end

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ack); // R12
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ack); // R12
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_enable |-> !irq); // R9
  AST_OFF_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_enable |-> !tx_rd_avail); // R9
  AST_NARROW_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_be != 4'hF) |=> ($stable(eng_enable) && $stable(eng_own_addr))); // R11
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && ctrl_rd_q) |-> (rsp_rdata[2:1] == 2'b00 && !rsp_rdata[14] && rsp_rdata[24:19] == 6'd0)); // R3
  AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && data_rd_q) |-> (rsp_rdata[31:8] == 24'd0)); // R6
  AST_DROP_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_drop && !tx_rd) |=> tx_full); // R7

endmodule

bind tgt_regbank tgt_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_be       (req_be),
  .rsp_ack      (rsp_ack),
  .rsp_rdata    (rsp_rdata),
  .eng_enable   (eng_enable),
  .eng_own_addr (eng_own_addr),
  .tx_rd        (tx_rd),
  .tx_rd_avail  (tx_rd_avail),
  .tx_full      (tx_full),
  .tx_push_drop (tx_push_drop),
  .irq          (irq)
);

// File: tb/tgt_regbank_tb_top.sv
module tgt_regbank_tb_top;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]  req_be = 4'h0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ack;
  logic [31:0] rsp_rdata;
  logic        eng_enable, eng_slow_sample;
  logic [6:0]  eng_own_addr;
  logic        eng_busy = 1'b0, eng_scl_sense = 1'b1, eng_sda_sense = 1'b1;
  logic        rx_wr_valid = 1'b0;
  logic [7:0]  rx_wr_data = '0;
  logic        tx_rd = 1'b0;
  logic [7:0]  tx_rd_data;
  logic        tx_rd_avail, irq;

  always #5 clk = ~clk;

  tgt_regbank #(.FIFO_DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (.*);

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  int total = 0;
  int bad   = 0;

  // depth field computed by a plain doubling search
  function automatic logic [31:0] depth_field();
    int n = 0;
    int v = 1;
    while (v < DEPTH) begin v = v * 2; n++; end
    return 32'(n) << 15;
  endfunction

  localparam logic [31:0] SENSE = (32'd1 << 29) | (32'd1 << 30);
  localparam logic [31:0] TXE   = 32'd1 << 27;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] be);
    item_t it;
    @(negedge clk);
    it.is_rd = 1'b0; it.exp = '0; it.tag = "R12";
    sb_q.push_back(it);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    it.is_rd = 1'b1; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic eng_push(logic [7:0] b);
    @(negedge clk);
    rx_wr_valid = 1'b1; rx_wr_data = b;
    @(negedge clk);
    rx_wr_valid = 1'b0;
  endtask

  task automatic eng_pop(logic [7:0] exp, string tag);
    @(negedge clk);
    check(tx_rd_avail === 1'b1 && tx_rd_data === exp, tag, {23'd0, tx_rd_avail, tx_rd_data}, {24'd1, exp});
    tx_rd = 1'b1;
    @(negedge clk);
    tx_rd = 1'b0;
  endtask

  // monitor: pops the scoreboard on each acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_ack) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R12 stray ack", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.is_rd) check(rsp_rdata === it.exp, it.tag, rsp_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] c1, c2, c3;
    logic [31:0] df;
    df = depth_field();
    c1 = 32'h1 | 32'h8 | (32'h5A << 4) | (32'd1 << 13);
    c2 = 32'h1 | (32'h5A << 4) | (32'd1 << 11);
    c3 = 32'h1 | (32'd1 << 12);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(eng_enable === 1'b0 && eng_slow_sample === 1'b0 && eng_own_addr === 7'd0, "R1 cfg outputs",
          {24'd0, eng_enable, eng_slow_sample, eng_own_addr[5:0]}, 32'd0);
    check(irq === 1'b0 && tx_rd_avail === 1'b0, "R1 irq/tx", {30'd0, irq, tx_rd_avail}, 32'd0);
    bus_rd(4'h0, df | TXE | SENSE, "R1 R3 R4 reset ctrl read");

    // R2 field layout and engine outputs
    bus_wr(4'h0, c1, 4'hF);
    check(eng_enable === 1'b1 && eng_slow_sample === 1'b1 && eng_own_addr === 7'h5A, "R2 engine fields",
          {23'd0, eng_enable, eng_slow_sample, eng_own_addr}, {23'd0, 2'b11, 7'h5A});
    check(irq === 1'b1, "R10 tx empty irq", {31'd0, irq}, 32'd1);
    bus_rd(4'h0, c1 | df | TXE | SENSE, "R2 ctrl readback");

    // R11 narrow control write ignored
    bus_wr(4'h0, 32'h0000_0006, 4'h3);
    check(eng_enable === 1'b1 && eng_own_addr === 7'h5A, "R11 narrow ctrl write",
          {24'd0, eng_enable, eng_own_addr}, {24'd1, 7'h5A});

    // R5 R7 transmit path, fifth push dropped
    for (int i = 1; i <= 5; i++) bus_wr(4'h4, 32'hABCD_0000 | (32'(i) * 32'h11), 4'hF);
    check(irq === 1'b0, "R10 tx not empty", {31'd0, irq}, 32'd0);
    bus_rd(4'h0, c1 | df | (32'd1 << 28) | SENSE, "R4 R7 tx full status");
    for (int i = 1; i <= 4; i++) eng_pop(8'(i * 8'h11), "R5 R7 tx order");
    @(negedge clk);
    check(tx_rd_avail === 1'b0 && tx_rd_data === 8'hFF, "R5 tx empty shows FF",
          {23'd0, tx_rd_avail, tx_rd_data}, 32'h0FF);

    // R6 R7 receive path
    for (int i = 0; i < 5; i++) eng_push(8'hA1 + 8'(i));
    eng_busy = 1'b1; eng_scl_sense = 1'b0;
    bus_rd(4'h0, c1 | df | (32'd1 << 25) | (32'd1 << 26) | TXE | (32'd1 << 30) | (32'd1 << 31),
           "R4 rx full busy sense");
    eng_busy = 1'b0; eng_scl_sense = 1'b1;
    for (int i = 0; i < 4; i++) bus_rd(4'h4, 32'hA1 + 32'(i), "R6 R7 rx order");
    bus_rd(4'h4, 32'd0, "R6 empty read zero");

    // R10 R8 receive-available mask and receive clear
    bus_wr(4'h0, c2, 4'hF);
    check(irq === 1'b0, "R10 rxa mask rx empty", {31'd0, irq}, 32'd0);
    eng_push(8'h77);
    check(irq === 1'b1, "R10 rx avail irq", {31'd0, irq}, 32'd1);
    bus_wr(4'h0, c2 | 32'h2, 4'hF);
    check(irq === 1'b0, "R8 rx clear drops irq", {31'd0, irq}, 32'd0);
    bus_rd(4'h0, c2 | df | TXE | SENSE, "R8 clear bits read zero");

    // R10 receive-full mask
    bus_wr(4'h0, c3, 4'hF);
    for (int i = 0; i < 3; i++) eng_push(8'h30 + 8'(i));
    check(irq === 1'b0, "R10 rx not yet full", {31'd0, irq}, 32'd0);
    eng_push(8'h33);
    check(irq === 1'b1, "R10 rx full irq", {31'd0, irq}, 32'd1);
    bus_wr(4'h0, c3 | 32'h2, 4'hF);

    // R8 transmit clear
    bus_wr(4'h4, 32'h01, 4'hF);
    bus_wr(4'h4, 32'h02, 4'hF);
    check(tx_rd_avail === 1'b1, "R5 tx avail", {31'd0, tx_rd_avail}, 32'd1);
    bus_wr(4'h0, c3 | 32'h4, 4'hF);
    check(tx_rd_avail === 1'b0, "R8 tx clear", {31'd0, tx_rd_avail}, 32'd0);

    // R9 disable flushes and blocks
    bus_wr(4'h4, 32'h09, 4'hF);
    eng_push(8'h10);
    bus_wr(4'h0, 32'd1 << 13, 4'hF);
    check(eng_enable === 1'b0 && irq === 1'b0 && tx_rd_avail === 1'b0, "R9 disable",
          {29'd0, eng_enable, irq, tx_rd_avail}, 32'd0);
    bus_wr(4'h4, 32'h33, 4'hF);
    eng_push(8'h44);
    bus_wr(4'h0, 32'h1, 4'hF);
    bus_rd(4'h0, 32'h1 | df | TXE | SENSE, "R9 fifos empty after re-enable");
    bus_rd(4'h4, 32'd0, "R9 no rx byte kept");

    // R12 unused offset, R11 narrow data write
    bus_rd(4'h8, 32'd0, "R12 unused offset");
    bus_wr(4'h4, 32'hEE, 4'h1);
    check(tx_rd_avail === 1'b0, "R11 narrow data write", {31'd0, tx_rd_avail}, 32'd0);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R12 all requests acked", 32'(sb_q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule